// File: doc/BRIEF.md
# SPI Word Queues with Event Status

This block sits between a register bus and a serial shift engine. It buffers 32-bit words in two queues of eight entries each. The bus side writes words into the transmit queue, and the engine drains them one at a time. The engine deposits received words into the receive queue, and the bus pops them by reading. The fill level of both queues is readable from a single packed register.

Both fill levels are compared each cycle against programmable limits. When the transmit queue has drained to its limit, or the receive queue has filled to its limit, a sticky event bit is raised in a status register. Three further events are also latched there: a completed transfer, a pop from the transmit queue while it is empty, and a push into the receive queue while it is full. Software clears a latched bit by writing a 1 to it. The status register also shows, without latching, whether the engine is mid-transfer.

A five-bit enable mask selects which latched events drive the single interrupt line. The enable mask is numbered differently from the status bits. Bus access uses plain read and write strobes with a 3-bit word address, and read data is combinational.

Top module: `spi_fifo_stat`

## Requirements
- R1: After synchronous reset both queues are empty, the count register reads 0, the enable register reads 0, the limit register reads 0x80, the interrupt is low, and status reads 0 until the first clock edge after reset.
- R2: Each queue returns words in the order they entered and holds at most 8 words. The count register (address 3) carries the receive count in bits [3:0] and the transmit count in bits [7:4]. A bus write to address 4 while the transmit queue holds 8 words is dropped.
- R3: The limit register (address 2) holds the transmit limit in bits [3:0] and the receive limit in bits [7:4]. Status bit 2 is set when the transmit count is at or below its limit. Status bit 3 is set when the receive count is at or above its limit. Each is set at the edge after the count meets the condition.
- R4: Status bits 1 to 5 are sticky. A write to address 0 clears each bit written as 1 and leaves bits written as 0 alone. An event that occurs in the same cycle as the clear wins.
- R5: An engine pop while the transmit queue is empty presents 0 on the engine data output, leaves the count at 0, and sets status bit 4.
- R6: An engine push while the receive queue holds 8 words, with no bus pop in that cycle, drops the word, keeps the stored words unchanged, and sets status bit 5.
- R7: Status bit 0 always equals the engine busy input. Writes to it have no effect.
- R8: A pulse on the engine done input sets status bit 1.
- R9: The interrupt is high exactly when an enabled event is latched. The mapping is enable bit 0 to done (status 1), bit 1 to transmit limit (status 2), bit 2 to receive limit (status 3), bit 3 to underflow (status 4), and bit 4 to overflow (status 5).
- R10: Address 1 holds the 5-bit enable mask, and its upper bits read 0. A read strobe at address 5 pops the receive queue and returns the head word. A read at address 5 on an empty receive queue returns 0 and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Bus write strobe |
| reg_rd | input | 1 | Bus read strobe (pops at address 5) |
| reg_addr | input | 3 | Bus word address: 0 status, 1 enable, 2 limits, 3 counts, 4 transmit data, 5 receive data |
| reg_wdata | input | 32 | Bus write data |
| reg_rdata | output | 32 | Combinational bus read data |
| eng_pending | input | 1 | Engine is mid-transfer |
| eng_done | input | 1 | One-cycle pulse marking a finished transfer |
| eng_tx_pop | input | 1 | Engine takes the transmit head word |
| eng_tx_data | output | 32 | Transmit head word, 0 when empty |
| eng_rx_push | input | 1 | Engine delivers a received word |
| eng_rx_data | input | 32 | Received word |
| irq | output | 1 | Interrupt request |

## Verification
The bench fills the transmit queue to eight and writes a ninth word. A design that wrapped its pointer would overwrite the oldest word and show a count of 0 or 9. It then drains past empty, where a wrong design would repeat a stale word instead of returning 0 and raising underflow. It overflows the receive queue and reads it back, which catches a design that stores the extra word or corrupts the head.

Limit windows are probed on both sides of the boundary. This exposes a strict comparison used in place of an inclusive one, and a clear that loses to an event in the same cycle. The interrupt is driven through each enable bit in turn, which catches a design that indexes the enables in status order. A long random mix of pushes and pops is compared against bench queues.

// File: rtl/spiq_pkg.sv
package spiq_pkg;

    typedef enum logic [2:0] {
        RA_STATUS = 3'd0,
        RA_IRQEN  = 3'd1,
        RA_LIMIT  = 3'd2,
        RA_COUNT  = 3'd3,
        RA_TXDATA = 3'd4,
        RA_RXDATA = 3'd5
    } reg_addr_e;

    localparam int unsigned EN_W = 5;

    // status register layout, bit 5 down to bit 0
    typedef struct packed {
        logic ovf;    // bit 5
        logic unf;    // bit 4
        logic rx_lim; // bit 3
        logic tx_lim; // bit 2
        logic done;   // bit 1
        logic busy;   // bit 0
    } status_t;

    localparam int unsigned ST_W = $bits(status_t);

    // enable bit i gates status bit i+1
    function automatic logic irq_of(status_t s, logic [EN_W-1:0] en);
        return (en[0] & s.done) | (en[1] & s.tx_lim) | (en[2] & s.rx_lim)
             | (en[3] & s.unf)  | (en[4] & s.ovf);
    endfunction

endpackage

// File: rtl/spiq_fifo.sv
module spiq_fifo #(
    parameter int unsigned W     = 32,
    parameter int unsigned DEPTH = 8,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1),
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [W-1:0]     push_data,
    input  logic             pop,
    output logic [W-1:0]     head,
    output logic [CNT_W-1:0] count
);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             empty, full, pop_ok, push_ok;

    assign empty   = (count == '0);
    assign full    = (count == CNT_W'(DEPTH));
    assign pop_ok  = pop && !empty;
    assign push_ok = push && (!full || pop_ok);
    assign head    = empty ? '0 : mem[rd_ptr];

    function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) begin
                mem[wr_ptr] <= push_data;
                wr_ptr      <= bump(wr_ptr);
            end
            if (pop_ok)
                rd_ptr <= bump(rd_ptr);
            if (push_ok && !pop_ok)
                count <= count + 1'b1;
            else if (pop_ok && !push_ok)
                count <= count - 1'b1;
        end
    end

endmodule

// File: rtl/spiq_status.sv
module spiq_status
    import spiq_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             eng_pending,
    input  logic             eng_done,
    input  logic             tx_pop,
    input  logic             rx_push,
    input  logic             rx_pop,
    input  logic [CNT_W-1:0] tx_cnt,
    input  logic [CNT_W-1:0] rx_cnt,
    input  logic [CNT_W-1:0] tx_lim,
    input  logic [CNT_W-1:0] rx_lim,
    input  logic             clr_wr,
    input  logic [ST_W-1:0]  clr_mask,
    input  logic [EN_W-1:0]  irq_en,
    output status_t          stat,
    output logic             irq
);

    status_t sticky_q, set_v, clr_v;

    always_comb begin
        set_v        = '0;
        set_v.done   = eng_done;
        set_v.tx_lim = (tx_cnt <= tx_lim);
        set_v.rx_lim = (rx_cnt >= rx_lim);
        set_v.unf    = tx_pop && (tx_cnt == '0);
        set_v.ovf    = rx_push && (rx_cnt == CNT_W'(DEPTH)) && !rx_pop;
        clr_v        = clr_wr ? status_t'(clr_mask) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst)
            sticky_q <= '0;
        else
            sticky_q <= (sticky_q & ~clr_v) | set_v;
    end

    always_comb begin
        stat      = sticky_q;
        stat.busy = eng_pending;
    end

    assign irq = irq_of(stat, irq_en);

endmodule

// File: rtl/spi_fifo_stat.sv
module spi_fifo_stat
    import spiq_pkg::*;
#(
    parameter int unsigned WORD_W     = 32,
    parameter int unsigned FIFO_DEPTH = 8,
    localparam int unsigned CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [2:0]        reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic              eng_pending,
    input  logic              eng_done,
    input  logic              eng_tx_pop,
    output logic [WORD_W-1:0] eng_tx_data,
    input  logic              eng_rx_push,
    input  logic [WORD_W-1:0] eng_rx_data,
    output logic              irq
);

    localparam logic [2*CNT_W-1:0] LIM_RST = {CNT_W'(FIFO_DEPTH), CNT_W'(0)};

    logic [EN_W-1:0]    en_q;
    logic [2*CNT_W-1:0] lim_q;
    logic [CNT_W-1:0]   tx_cnt, rx_cnt;
    logic [WORD_W-1:0]  rx_head;
    logic               bus_tx_push, bus_rx_pop, stat_wr;
    status_t            stat;

    assign bus_tx_push = reg_wr && (reg_addr == RA_TXDATA);
    assign bus_rx_pop  = reg_rd && (reg_addr == RA_RXDATA);
    assign stat_wr     = reg_wr && (reg_addr == RA_STATUS);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= '0;
            lim_q <= LIM_RST;
        end else if (reg_wr) begin
            if (reg_addr == RA_IRQEN) en_q  <= reg_wdata[EN_W-1:0];
            if (reg_addr == RA_LIMIT) lim_q <= reg_wdata[2*CNT_W-1:0];
        end
    end

    spiq_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst(rst),
        .push(bus_tx_push), .push_data(reg_wdata),
        .pop(eng_tx_pop), .head(eng_tx_data), .count(tx_cnt)
    );

    spiq_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst(rst),
        .push(eng_rx_push), .push_data(eng_rx_data),
        .pop(bus_rx_pop), .head(rx_head), .count(rx_cnt)
    );

    spiq_status #(.DEPTH(FIFO_DEPTH)) u_stat (
        .clk(clk), .rst(rst),
        .eng_pending(eng_pending), .eng_done(eng_done),
        .tx_pop(eng_tx_pop), .rx_push(eng_rx_push), .rx_pop(bus_rx_pop),
        .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
        .tx_lim(lim_q[CNT_W-1:0]), .rx_lim(lim_q[2*CNT_W-1:CNT_W]),
        .clr_wr(stat_wr), .clr_mask(reg_wdata[ST_W-1:0]),
        .irq_en(en_q), .stat(stat), .irq(irq)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_STATUS: reg_rdata[ST_W-1:0]    = stat;
            RA_IRQEN:  reg_rdata[EN_W-1:0]    = en_q;
            RA_LIMIT:  reg_rdata[2*CNT_W-1:0] = lim_q;
            RA_COUNT:  reg_rdata[2*CNT_W-1:0] = {tx_cnt, rx_cnt};
            RA_RXDATA: reg_rdata              = rx_head;
            default:   reg_rdata              = '0;
        endcase
    end

endmodule

// File: rtl/spiq_checker.sv
module spiq_checker
    import spiq_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             reg_wr,
    input logic             reg_rd,
    input logic [2:0]       reg_addr,
    input logic [31:0]      reg_wdata,
    input logic             eng_done,
    input logic             eng_tx_pop,
    input logic             eng_rx_push,
    input logic             irq,
    input logic [CNT_W-1:0] tx_cnt,
    input logic [CNT_W-1:0] rx_cnt,
    input logic [EN_W-1:0]  en_q,
    input status_t          stat
);

    logic bus_pop;
    assign bus_pop = reg_rd && (reg_addr == 3'd5);

    a_r2_count_bound: assert property (@(posedge clk) disable iff (rst)
        (tx_cnt <= CNT_W'(DEPTH)) && (rx_cnt <= CNT_W'(DEPTH)));

    a_r5_underflow_sets: assert property (@(posedge clk) disable iff (rst)
        (eng_tx_pop && tx_cnt == '0) |=> (stat.unf && tx_cnt == '0));

    a_r6_overflow_sets: assert property (@(posedge clk) disable iff (rst)
        (eng_rx_push && rx_cnt == CNT_W'(DEPTH) && !bus_pop) |=> stat.ovf);

    a_r6_drop_keeps_count: assert property (@(posedge clk) disable iff (rst)
        (eng_rx_push && rx_cnt == CNT_W'(DEPTH) && !bus_pop) |=> $stable(rx_cnt));

    a_r8_done_sets: assert property (@(posedge clk) disable iff (rst)
        eng_done |=> stat.done);

    a_r4_clear_done: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 3'd0 && reg_wdata[1] && !eng_done) |=> !stat.done);

    a_r4_done_sticky: assert property (@(posedge clk) disable iff (rst)
        (stat.done && !(reg_wr && reg_addr == 3'd0 && reg_wdata[1])) |=> stat.done);

    a_r9_irq_masked: assert property (@(posedge clk) disable iff (rst)
        (en_q == '0) |-> !irq);

endmodule

bind spi_fifo_stat spiq_checker #(.DEPTH(FIFO_DEPTH)) u_chk (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .eng_done(eng_done),
    .eng_tx_pop(eng_tx_pop), .eng_rx_push(eng_rx_push), .irq(irq),
    .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .en_q(en_q), .stat(stat)
);

// File: tb/spi_fifo_stat_tb.sv
`timescale 1ns/100ps
module spi_fifo_stat_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 0, reg_rd = 0;
    logic [2:0]  reg_addr = 0;
    logic [31:0] reg_wdata = 0, reg_rdata;
    logic        eng_pending = 0, eng_done = 0, eng_tx_pop = 0, eng_rx_push = 0;
    logic [31:0] eng_tx_data, eng_rx_data = 0;
    logic        irq;

    int checks = 0, failures = 0;
    bit finished = 0;
    logic [31:0] txq[$], rxq[$];
    logic exp_unf, exp_ovf;

    always #2 clk = ~clk;

    spi_fifo_stat u_dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .eng_pending(eng_pending), .eng_done(eng_done),
        .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data),
        .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data), .irq(irq)
    );

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic check_eq(input string req, input logic [31:0] act,
                            input logic [31:0] exp);
        check(act === exp, req, act, exp);
    endtask

    function automatic logic [31:0] counts_of(int tx, int rx);
        return {24'd0, 4'(tx), 4'(rx)};
    endfunction

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #0.2;
    endtask

    task automatic peek(input logic [2:0] a, output logic [31:0] v);
        reg_addr = a;
        #0.2;
        v = reg_rdata;
    endtask

    task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1;
        @(posedge clk); #0.2;
        reg_wr = 0;
    endtask

    task automatic bus_rd(input logic [2:0] a, output logic [31:0] v);
        reg_addr = a; reg_rd = 1;
        #0.2;
        v = reg_rdata;
        @(posedge clk); #0.2;
        reg_rd = 0;
    endtask

    task automatic eng_pop(output logic [31:0] v);
        eng_tx_pop = 1;
        #0.2;
        v = eng_tx_data;
        @(posedge clk); #0.2;
        eng_tx_pop = 0;
    endtask

    task automatic eng_push(input logic [31:0] d);
        eng_rx_data = d; eng_rx_push = 1;
        @(posedge clk); #0.2;
        eng_rx_push = 0;
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'h5a17));
        repeat (3) @(posedge clk);
        #0.2 rst = 0;

        // R1 reset state
        peek(3'd3, v); check_eq("R1 counts", v, 32'h0);
        peek(3'd2, v); check_eq("R1 limits", v, 32'h80);
        peek(3'd1, v); check_eq("R1 enable", v, 32'h0);
        peek(3'd0, v); check_eq("R1 status", v, 32'h0);
        check_eq("R1 irq", {31'd0, irq}, 32'h0);
        idle(1);
        peek(3'd0, v); check_eq("R3 tx limit after reset", v, 32'h04);

        // R7 busy bit is live, not writable
        eng_pending = 1;
        peek(3'd0, v); check_eq("R7 busy high", v & 32'h1, 32'h1);
        bus_wr(3'd0, 32'h3F);
        peek(3'd0, v); check_eq("R7 busy survives write", v & 32'h1, 32'h1);
        eng_pending = 0;
        peek(3'd0, v); check_eq("R7 busy low", v & 32'h1, 32'h0);

        // R8 / R4 done latch and clear
        eng_done = 1; @(posedge clk); #0.2; eng_done = 0;
        idle(3);
        peek(3'd0, v); check_eq("R8 done sticky", v & 32'h2, 32'h2);
        bus_wr(3'd0, 32'h0);
        peek(3'd0, v); check_eq("R4 zero write keeps", v & 32'h2, 32'h2);

        // R9 enable mapping
        bus_wr(3'd1, 32'h01); #0.2;
        check_eq("R9 done enabled", {31'd0, irq}, 32'h1);
        bus_wr(3'd1, 32'h10); #0.2;
        check_eq("R9 ovf enable only", {31'd0, irq}, 32'h0);
        bus_wr(3'd1, 32'h02); #0.2;
        check_eq("R9 tx limit enable", {31'd0, irq}, 32'h1);
        bus_wr(3'd1, 32'hFFFF_FFFF);
        peek(3'd1, v); check_eq("R10 enable width", v, 32'h1F);
        bus_wr(3'd1, 32'h0);
        bus_wr(3'd0, 32'h02);
        peek(3'd0, v); check_eq("R4 clear done", v & 32'h2, 32'h0);

        // R3 limit windows: tx limit 3, rx limit 4
        bus_wr(3'd2, 32'h43);
        idle(1);
        bus_wr(3'd0, 32'h3F);
        peek(3'd0, v); check_eq("R4 event wins over clear", v & 32'h0C, 32'h04);
        for (int i = 0; i < 4; i++) bus_wr(3'd4, 32'h100 + i);
        bus_wr(3'd0, 32'h3F);
        peek(3'd0, v); check_eq("R3 tx above limit", v & 32'h04, 32'h0);
        eng_pop(v); check_eq("R2 tx order", v, 32'h100);
        idle(1);
        peek(3'd0, v); check_eq("R3 tx at limit", v & 32'h04, 32'h04);
        for (int i = 1; i < 4; i++) begin
            eng_pop(v); check_eq("R2 tx order", v, 32'h100 + i);
        end
        for (int i = 0; i < 3; i++) eng_push(32'h200 + i);
        idle(1);
        peek(3'd0, v); check_eq("R3 rx below limit", v & 32'h08, 32'h0);
        eng_push(32'h203);
        idle(1);
        peek(3'd0, v); check_eq("R3 rx at limit", v & 32'h08, 32'h08);
        bus_wr(3'd1, 32'h04); #0.2;
        check_eq("R9 rx limit enable", {31'd0, irq}, 32'h1);
        bus_wr(3'd1, 32'h08); #0.2;
        check_eq("R9 unf enable clear", {31'd0, irq}, 32'h0);
        for (int i = 0; i < 4; i++) begin
            bus_rd(3'd5, v); check_eq("R10 rx pop", v, 32'h200 + i);
        end
        bus_wr(3'd2, 32'h80);

        // R2 / R5 transmit fill and drain past empty
        for (int i = 0; i < 9; i++) bus_wr(3'd4, 32'hA000 + i);
        peek(3'd3, v); check_eq("R2 tx full count", v, counts_of(8, 0));
        for (int i = 0; i < 8; i++) begin
            eng_pop(v); check_eq("R2 tx drop ninth", v, 32'hA000 + i);
        end
        eng_pop(v); check_eq("R5 empty data", v, 32'h0);
        peek(3'd3, v); check_eq("R5 count stays 0", v, 32'h0);
        peek(3'd0, v); check_eq("R5 underflow bit", v & 32'h10, 32'h10);
        #0.2; check_eq("R9 unf irq", {31'd0, irq}, 32'h1);

        // R6 / R10 receive overflow
        for (int i = 0; i < 9; i++) eng_push(32'hB000 + i);
        peek(3'd0, v); check_eq("R6 overflow bit", v & 32'h20, 32'h20);
        peek(3'd3, v); check_eq("R6 rx count", v, counts_of(0, 8));
        for (int i = 0; i < 8; i++) begin
            bus_rd(3'd5, v); check_eq("R6 rx contents", v, 32'hB000 + i);
        end
        bus_rd(3'd5, v); check_eq("R10 empty read", v, 32'h0);
        peek(3'd3, v); check_eq("R10 empty read count", v, 32'h0);
        bus_wr(3'd1, 32'h0);

        // random mix against bench queues
        bus_wr(3'd0, 32'h3F);
        exp_unf = 0; exp_ovf = 0;
        for (int n = 0; n < 600; n++) begin
            logic [31:0] d, e;
            case ($urandom_range(0, 3))
                0: begin
                    d = $urandom;
                    bus_wr(3'd4, d);
                    if (txq.size() < 8) txq.push_back(d);
                end
                1: begin
                    e = (txq.size() > 0) ? txq[0] : 32'h0;
                    eng_pop(d);
                    check_eq("R2 random tx data", d, e);
                    if (txq.size() > 0) void'(txq.pop_front()); else exp_unf = 1;
                end
                2: begin
                    d = $urandom;
                    eng_push(d);
                    if (rxq.size() < 8) rxq.push_back(d); else exp_ovf = 1;
                end
                default: begin
                    e = (rxq.size() > 0) ? rxq[0] : 32'h0;
                    bus_rd(3'd5, d);
                    check_eq("R10 random rx data", d, e);
                    if (rxq.size() > 0) void'(rxq.pop_front());
                end
            endcase
            peek(3'd3, v);
            check_eq("R2 random counts", v, counts_of(txq.size(), rxq.size()));
            peek(3'd0, v);
            check_eq("R5 R6 random flags", v & 32'h30, {26'd0, exp_ovf, exp_unf, 4'd0});
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule